// File: doc/BRIEF.md
# Serial Port Register File and Interrupt Logic

This block is the bus side of a simple serial port. It holds the status, receive data, baud divisor, three control words and a guard/prescaler word behind a word-addressed read/write port that spans a 1 KiB window. It also drives the port's single level interrupt. Bit timing, baud generation, parity, framing and smartcard features live elsewhere. The transmitter is assumed to take each byte in the cycle it is offered.

On the receive side the block takes one byte at a time over a ready/valid handshake. Ready is high only while no unread byte is held, so the block never overruns. A byte offered while the port or its receiver is disabled is taken and then thrown away. On the transmit side each accepted data write produces a one-cycle strobe that carries the low byte. Reads of the data register and writes to the status register have side effects on the flags and the interrupt.

Bus accesses are single-cycle. Read data is combinational from the address in the same cycle, and all state changes take effect at the clock edge. If a receive byte is accepted in the same cycle as a bus write, the receive update is applied after the bus write and takes priority over it.

Top module: `serial_reg_if`

## Requirements
- R1: `rx_ready_o` is high exactly when receive-not-empty (status bit 5) is clear. While a byte is held, further offered bytes are not taken and the held byte is unchanged.
- R2: A byte that completes the handshake is discarded, with no flag or data change, unless both port-enable (control 1 bit 13) and receiver-enable (control 1 bit 2) are set.
- R3: A stored byte sets status bit 5 at the next edge. If receive-interrupt-enable (control 1 bit 5) was set in the accepting cycle, `irq_o` is high from the next cycle.
- R4: A read at byte offset 0x04 returns the held byte in bits 7:0 with all other bits 0. The read clears status bit 5 and drops `irq_o` at the next edge.
- R5: A status write (offset 0x00) with a value of 0x3FF or less loads the value's low 10 bits with bit 7 (transmit-empty) forced to 1. A larger value ANDs its low 10 bits into the current status. Status reads return the 10-bit status with zero above.
- R6: After a status write, `irq_o` is low when the resulting status bit 5 is clear.
- R7: A data write (offset 0x04) with a value below 0xF000 makes `tx_valid_o` high for exactly the next cycle, carrying the value's low byte, and sets status bit 6 (transmission-complete). Values of 0xF000 or more have no effect.
- R8: A control 1 write (offset 0x0C) with bit 5 set while status bit 5 is set raises `irq_o` at the next edge.
- R9: After reset the status reads 0x0C0, every other register reads 0, and `irq_o` and `tx_valid_o` are low.
- R10: Baud (0x08), control 1 to 3 (0x0C, 0x10, 0x14) and guard (0x18) read back the last 32-bit value written. Any other offset reads 0, and writes to it change nothing. Address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 10 | Byte address inside the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the access cycle |
| rx_valid_i | input | 1 | Receive byte offered |
| rx_data_i | input | 8 | Receive byte |
| rx_ready_o | output | 1 | Block can take a receive byte |
| tx_valid_o | output | 1 | One-cycle transmit strobe |
| tx_data_o | output | 8 | Transmit byte |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume at most one bus access per cycle and no change of the inputs between edges. Several of them also assume that no bus access or receive offer overlaps the cycle under test, so that a single cause is isolated. The bench drives every input once per cycle at the falling edge. It mixes random bus traffic and random receive offers with idle cycles, which exercises both the isolated cases the assertions target and the same-cycle overlaps that only the bench's reference model covers.

// File: rtl/serial_reg_pkg.sv
package serial_reg_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned ADDR_W  = 10;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned STAT_W  = 10;
  localparam int unsigned NUM_REG = 7;
  localparam int unsigned NUM_CFG = 5;

  // word index of each register
  localparam int unsigned IDX_STAT  = 0;
  localparam int unsigned IDX_DATA  = 1;
  localparam int unsigned IDX_CFG0  = 2;
  localparam int unsigned IDX_CTL1  = 3;

  localparam int unsigned BIT_TXE  = 7;
  localparam int unsigned BIT_TC   = 6;
  localparam int unsigned BIT_RXNE = 5;
  localparam int unsigned BIT_RXIE = 5;
  localparam int unsigned BIT_RXEN = 2;
  localparam int unsigned BIT_EN   = 13;

  localparam logic [STAT_W-1:0] STAT_RST  = 10'h0C0;
  localparam logic [REG_W-1:0]  LOAD_MAX  = 32'h0000_03FF;
  localparam logic [REG_W-1:0]  TX_LIMIT  = 32'h0000_F000;
endpackage

// File: rtl/serial_addr_dec.sv
module serial_addr_dec #(
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned NUM_REG = 7
) (
  input  logic [ADDR_W-3:0]  widx_i,
  input  logic               req_i,
  input  logic               we_i,
  output logic [NUM_REG-1:0] rd_sel_o,
  output logic [NUM_REG-1:0] wr_sel_o
);
  localparam int unsigned WIDX_W = ADDR_W - 2;

  for (genvar g = 0; g < NUM_REG; g++) begin : g_sel
    logic hit;
    assign hit         = (widx_i == WIDX_W'(g));
    assign rd_sel_o[g] = req_i & ~we_i & hit;
    assign wr_sel_o[g] = req_i & we_i & hit;
  end
endmodule

// File: rtl/serial_cfg_bank.sv
module serial_cfg_bank #(
  parameter int unsigned REG_W   = 32,
  parameter int unsigned NUM_CFG = 5
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_CFG-1:0]            wr_i,
  input  logic [REG_W-1:0]              wdata_i,
  output logic [NUM_CFG-1:0][REG_W-1:0] q_o
);
  for (genvar g = 0; g < NUM_CFG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    q_o[g] <= '0;
      else if (wr_i[g]) q_o[g] <= wdata_i;
    end
  end
endmodule

// File: rtl/serial_stat_ctrl.sv
module serial_stat_ctrl
  import serial_reg_pkg::*;
#(
  parameter int unsigned REG_W_P  = REG_W,
  parameter int unsigned BYTE_W_P = BYTE_W,
  parameter int unsigned STAT_W_P = STAT_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                stat_wr_i,
  input  logic                data_rd_i,
  input  logic                data_wr_i,
  input  logic                ctl1_wr_i,
  input  logic [REG_W_P-1:0]  wdata_i,
  input  logic                port_on_i,
  input  logic                rx_ie_i,
  input  logic                rx_valid_i,
  input  logic [BYTE_W_P-1:0] rx_data_i,
  output logic                rx_ready_o,
  output logic [STAT_W_P-1:0] stat_o,
  output logic [BYTE_W_P-1:0] data_o,
  output logic                tx_valid_o,
  output logic [BYTE_W_P-1:0] tx_data_o,
  output logic                irq_o
);
  logic [STAT_W_P-1:0] stat_d;
  logic                irq_d;
  logic                rx_take, tx_go;

  assign rx_ready_o = ~stat_o[BIT_RXNE];
  assign rx_take    = rx_valid_i & rx_ready_o & port_on_i;
  assign tx_go      = data_wr_i & (wdata_i < TX_LIMIT);

  always_comb begin
    stat_d = stat_o;
    irq_d  = irq_o;
    if (stat_wr_i) begin
      if (wdata_i <= LOAD_MAX) begin
        stat_d          = wdata_i[STAT_W_P-1:0];
        stat_d[BIT_TXE] = 1'b1;
      end else begin
        stat_d = stat_o & wdata_i[STAT_W_P-1:0];
      end
      if (!stat_d[BIT_RXNE]) irq_d = 1'b0;
    end
    if (tx_go) stat_d[BIT_TC] = 1'b1;
    if (data_rd_i) begin
      stat_d[BIT_RXNE] = 1'b0;
      irq_d            = 1'b0;
    end
    if (ctl1_wr_i && wdata_i[BIT_RXIE] && stat_d[BIT_RXNE]) irq_d = 1'b1;
    // receive update is applied last and wins
    if (rx_take) begin
      stat_d[BIT_RXNE] = 1'b1;
      if (rx_ie_i) irq_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_o     <= STAT_RST;
      data_o     <= '0;
      irq_o      <= 1'b0;
      tx_valid_o <= 1'b0;
      tx_data_o  <= '0;
    end else begin
      stat_o     <= stat_d;
      irq_o      <= irq_d;
      tx_valid_o <= tx_go;
      if (rx_take) data_o <= rx_data_i;
      if (tx_go)   tx_data_o <= wdata_i[BYTE_W_P-1:0];
    end
  end
endmodule

// File: rtl/serial_reg_if.sv
module serial_reg_if
  import serial_reg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              rx_valid_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  output logic              rx_ready_o,
  output logic              tx_valid_o,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic              irq_o
);
  logic [NUM_REG-1:0]            rd_sel, wr_sel;
  logic [NUM_CFG-1:0][REG_W-1:0] cfg_q;
  logic [NUM_REG-1:0][REG_W-1:0] view;
  logic [STAT_W-1:0]             stat_w;
  logic [BYTE_W-1:0]             data_w;
  logic [REG_W-1:0]              ctl1_w;

  serial_addr_dec #(.ADDR_W(ADDR_W), .NUM_REG(NUM_REG)) u_dec (
    .widx_i  (addr_i[ADDR_W-1:2]),
    .req_i   (req_i),
    .we_i    (we_i),
    .rd_sel_o(rd_sel),
    .wr_sel_o(wr_sel)
  );

  serial_cfg_bank #(.REG_W(REG_W), .NUM_CFG(NUM_CFG)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_sel[NUM_REG-1:IDX_CFG0]),
    .wdata_i(wdata_i),
    .q_o    (cfg_q)
  );

  assign ctl1_w = cfg_q[IDX_CTL1-IDX_CFG0];

  serial_stat_ctrl u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stat_wr_i (wr_sel[IDX_STAT]),
    .data_rd_i (rd_sel[IDX_DATA]),
    .data_wr_i (wr_sel[IDX_DATA]),
    .ctl1_wr_i (wr_sel[IDX_CTL1]),
    .wdata_i   (wdata_i),
    .port_on_i (ctl1_w[BIT_EN] & ctl1_w[BIT_RXEN]),
    .rx_ie_i   (ctl1_w[BIT_RXIE]),
    .rx_valid_i(rx_valid_i),
    .rx_data_i (rx_data_i),
    .rx_ready_o(rx_ready_o),
    .stat_o    (stat_w),
    .data_o    (data_w),
    .tx_valid_o(tx_valid_o),
    .tx_data_o (tx_data_o),
    .irq_o     (irq_o)
  );

  assign view[IDX_STAT] = REG_W'(stat_w);
  assign view[IDX_DATA] = REG_W'(data_w);
  for (genvar g = 0; g < NUM_CFG; g++) begin : g_view
    assign view[IDX_CFG0+g] = cfg_q[g];
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REG; i++)
      if (rd_sel[i]) rdata_o = rdata_o | view[i];
  end
endmodule

// File: rtl/serial_reg_if_chk.sv
module serial_reg_if_chk
  import serial_reg_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [REG_W-1:0]  wdata_i,
  input logic [REG_W-1:0]  rdata_o,
  input logic              rx_valid_i,
  input logic              rx_ready_o,
  input logic              tx_valid_o,
  input logic [BYTE_W-1:0] tx_data_o,
  input logic              irq_o,
  input logic [STAT_W-1:0] stat_i,
  input logic [REG_W-1:0]  ctl1_i
);
  logic [ADDR_W-3:0] widx;
  logic              on;
  assign widx = addr_i[ADDR_W-1:2];
  assign on   = ctl1_i[BIT_EN] & ctl1_i[BIT_RXEN];

  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_ready_o && !req_i) |=> !rx_ready_o);

  p_drop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_ready_o && !on && !req_i) |=> rx_ready_o);

  p_take_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_ready_o && on && !req_i) |=> (!rx_ready_o && irq_o == $past(ctl1_i[BIT_RXIE])));

  p_rd_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && widx == 1 && !rx_valid_i) |=> (rx_ready_o && !irq_o));

  p_stat_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && widx == 0 && wdata_i <= LOAD_MAX && !rx_valid_i)
    |=> stat_i == ($past(wdata_i[STAT_W-1:0]) | 10'h080));

  p_irq_needs_rx_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !rx_ready_o);

  p_tx_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> $past(req_i && we_i && widx == 1 && wdata_i < TX_LIMIT));

  p_tx_byte_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> tx_data_o == $past(wdata_i[BYTE_W-1:0]));

  p_ie_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && widx == 3 && wdata_i[BIT_RXIE] && !rx_ready_o) |=> irq_o);

  p_unmapped_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && widx >= NUM_REG) |-> rdata_o == '0);
endmodule

bind serial_reg_if serial_reg_if_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .rx_valid_i(rx_valid_i),
  .rx_ready_o(rx_ready_o),
  .tx_valid_o(tx_valid_o),
  .tx_data_o (tx_data_o),
  .irq_o     (irq_o),
  .stat_i    (stat_w),
  .ctl1_i    (ctl1_w)
);

// File: tb/sim_serial_reg_if.sv
`timescale 1ns/1ps
module sim_serial_reg_if;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 0, we_i = 0, rx_valid_i = 0;
  logic [9:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [7:0]  rx_data_i = '0;
  logic [31:0] rdata_o;
  logic        rx_ready_o, tx_valid_o, irq_o;
  logic [7:0]  tx_data_o;

  always #4 clk = ~clk;

  serial_reg_if u0 (.clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .rx_valid_i(rx_valid_i),
    .rx_data_i(rx_data_i), .rx_ready_o(rx_ready_o), .tx_valid_o(tx_valid_o),
    .tx_data_o(tx_data_o), .irq_o(irq_o));

  int checks = 0, errors = 0;

  // reference model
  logic [9:0]  m_sr = 10'h0C0;
  logic [7:0]  m_dr = '0;
  logic [31:0] m_cfg [5];
  logic        m_irq = 0, m_tx = 0;
  logic [7:0]  m_txd = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [9:0] a);
    int idx = int'(a[9:2]);
    if (idx == 0) return {22'd0, m_sr};
    if (idx == 1) return {24'd0, m_dr};
    if (idx >= 2 && idx <= 6) return m_cfg[idx-2];
    return 32'd0;
  endfunction

  function automatic string rd_tag(input logic [9:0] a);
    int idx = int'(a[9:2]);
    if (idx == 0) return "R5";
    if (idx == 1) return "R4";
    return "R10";
  endfunction

  // called at a falling edge; returns at the next falling edge
  task automatic step(input logic rq, input logic w, input logic [9:0] a,
                      input logic [31:0] d, input logic rv, input logic [7:0] rd);
    int idx;
    logic [9:0] nsr;
    logic nirq, take;
    logic [31:0] c1;
    req_i = rq; we_i = w; addr_i = a; wdata_i = d; rx_valid_i = rv; rx_data_i = rd;
    #1;
    chk(rx_ready_o == !m_sr[5], "R1", {31'd0, rx_ready_o}, {31'd0, !m_sr[5]});
    if (rq && !w) chk(rdata_o == exp_read(a), rd_tag(a), rdata_o, exp_read(a));
    idx = int'(a[9:2]);
    c1 = m_cfg[1];
    take = rv && !m_sr[5] && c1[13] && c1[2];
    nsr = m_sr; nirq = m_irq; m_tx = 0;
    if (rq && w) begin
      if (idx == 0) begin
        nsr = (d <= 32'h3FF) ? (d[9:0] | 10'h080) : (m_sr & d[9:0]);
        if (!nsr[5]) nirq = 0;
      end else if (idx == 1) begin
        if (d < 32'hF000) begin nsr[6] = 1; m_tx = 1; m_txd = d[7:0]; end
      end else if (idx >= 2 && idx <= 6) begin
        m_cfg[idx-2] = d;
        if (idx == 3 && d[5] && nsr[5]) nirq = 1;
      end
    end
    if (rq && !w && idx == 1) begin nsr[5] = 0; nirq = 0; end
    if (take) begin m_dr = rd; nsr[5] = 1; if (c1[5]) nirq = 1; end
    m_sr = nsr; m_irq = nirq;
    @(posedge clk);
    @(negedge clk);
    chk(irq_o == m_irq, "R3", {31'd0, irq_o}, {31'd0, m_irq});
    chk(tx_valid_o == m_tx, "R7", {31'd0, tx_valid_o}, {31'd0, m_tx});
    if (m_tx) chk(tx_data_o == m_txd, "R7", {24'd0, tx_data_o}, {24'd0, m_txd});
    req_i = 0; rx_valid_i = 0;
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d); step(1, 1, a, d, 0, 0); endtask
  task automatic rd(input logic [9:0] a); step(1, 0, a, 0, 0, 0); endtask
  task automatic push(input logic [7:0] b); step(0, 0, 0, 0, 1, b); endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 5; i++) m_cfg[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R9 reset values
    chk(irq_o == 0 && tx_valid_o == 0, "R9", {30'd0, irq_o, tx_valid_o}, 0);
    for (int i = 0; i < 7; i++) begin
      req_i = 1; we_i = 0; addr_i = 10'(i * 4); #1;
      chk(rdata_o == (i == 0 ? 32'h0C0 : 32'h0), "R9", rdata_o, (i == 0 ? 32'h0C0 : 32'h0));
      req_i = 0;
      @(negedge clk);
    end
    // R2: disabled port drops byte
    push(8'h11);
    chk(rx_ready_o == 1, "R2", {31'd0, rx_ready_o}, 1);
    wr(10'h0C, (32'd1 << 13));
    push(8'h22);
    chk(rx_ready_o == 1, "R2", {31'd0, rx_ready_o}, 1);
    // enable with interrupt
    wr(10'h0C, (32'd1 << 13) | (32'd1 << 2) | (32'd1 << 5));
    push(8'h5A);
    push(8'hA5);
    rd(10'h04);
    // R8: enable interrupt after byte held
    wr(10'h0C, (32'd1 << 13) | (32'd1 << 2));
    push(8'h3C);
    chk(irq_o == 0, "R8", {31'd0, irq_o}, 0);
    wr(10'h0C, (32'd1 << 13) | (32'd1 << 2) | (32'd1 << 5));
    chk(irq_o == 1, "R8", {31'd0, irq_o}, 1);
    // R6: status writes
    wr(10'h00, 32'h0000_0020);
    wr(10'h00, 32'hFFFF_FFDF);
    chk(irq_o == 0, "R6", {31'd0, irq_o}, 0);
    rd(10'h00);
    wr(10'h00, 32'h0000_0000);
    rd(10'h00);
    // R7: transmit
    wr(10'h04, 32'h0000_F000);
    wr(10'h04, 32'h0000_1234);
    wr(10'h04, 32'h0000_EFFF);
    rd(10'h00);
    // R10: config and unmapped
    wr(10'h08, 32'hDEAD_BEEF); rd(10'h08); rd(10'h0B);
    wr(10'h18, 32'h0123_4567); rd(10'h18);
    wr(10'h1C, 32'hFFFF_FFFF); rd(10'h1C); rd(10'h3FC);
    for (int i = 0; i < 7; i++) rd(10'(i * 4));
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [9:0] a;
      logic [31:0] d;
      int sel = $urandom_range(0, 9);
      a = (sel < 8) ? 10'(sel * 4 + $urandom_range(0, 3)) : 10'($urandom_range(0, 1023));
      case ($urandom_range(0, 3))
        0: d = $urandom_range(0, 32'h3FF);
        1: d = $urandom;
        2: d = 32'hF000 + $urandom_range(0, 3) - 2;
        default: d = (32'd1 << 13) | (32'd1 << 2) | ($urandom_range(0, 1) << 5) | $urandom_range(0, 3);
      endcase
      if (a[9:2] == 3 && $urandom_range(0, 3) != 0) d = (d & ~32'h2004) | (32'd1 << 13) | (32'd1 << 2);
      step(1'($urandom_range(0, 2) != 0), 1'($urandom_range(0, 1)), a, d,
           1'($urandom_range(0, 1)), 8'($urandom));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule